// File: doc/BRIEF.md
# Five-Operand Modular Adder with Column Counters

This block sums five unsigned W-bit operands and returns the total modulo 2^W. It does not use a cascade of full-adder rows. Each bit column feeds its five equal-weight bits to a 5-to-3 counter cell, which writes the population count of those bits as a 3-bit binary number. The count bits are gathered into three vectors of weights 1, 2 and 4. One row of full adders reduces those three vectors to a sum vector and a carry vector. A ripple adder then resolves the pair into the final W-bit value.

The adder logic is combinational from the operand ports up to a single result register. A qualifier input marks each cycle that carries a valid operand set. One operand set can be accepted on every clock. The result and its qualifier appear one clock after the operands are sampled. While the qualifier is low, the result register keeps its value. An asynchronous active-low reset clears the block, and a two-stage synchronizer inside the block releases that reset on a clock edge.

Top module: `five_op_adder`

## Requirements
- R1: A counter cell receives five bits of equal weight and produces bits cnt0, cnt1 and cnt2 with cnt0 + 2·cnt1 + 4·cnt2 equal to the number of ones. When only bit 0 of each operand is used, sum_out equals that count (0 to 5).
- R2: The weight-2 count vector is shifted up by one bit position and the weight-4 count vector by two. As a result, five ones placed in column j add 5·2^j to the total.
- R3: On the clock after a cycle with in_valid high, sum_out equals (op_a + op_b + op_c + op_d + op_e) mod 2^W, using the operands sampled in that cycle.
- R4: Bits of weight 2^W or higher, whether they come from counter bits shifted past the top column or from carries out of the top column, are discarded. With five all-ones operands at W = 8, the result is 251.
- R5: out_valid equals in_valid delayed by one clock.
- R6: On the clock after a cycle with in_valid low, sum_out keeps its previous value, whatever the operands were.
- R7: While reset is asserted, out_valid is 0 and sum_out is 0.
- R8: Operand sets presented with in_valid high on consecutive clocks each give their own result on consecutive clocks, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the operands of this cycle as valid |
| op_a | input | W | Operand 1 |
| op_b | input | W | Operand 2 |
| op_c | input | W | Operand 3 |
| op_d | input | W | Operand 4 |
| op_e | input | W | Operand 5 |
| out_valid | output | 1 | Marks sum_out as a fresh result |
| sum_out | output | W | Sum of the five operands modulo 2^W |

## Verification
The bench sweeps all 32 patterns of ones in bit 0 of the five operands. This exercises every input pattern of a counter cell and separates the cnt1 and cnt2 weights from each other. It then fills one column at a time with five ones across all W columns. That sweep exposes misaligned or wrongly truncated count vectors at the top columns, where the shifted bits fall off. All-ones operands drive the overflow discard. A long back-to-back run of random operand sets, compared against a modular sum, checks the carry-save row and the ripple adder. Idle cycles with changing operands show that the result register holds its value.

// File: rtl/add5_pkg.sv
package add5_pkg;

  localparam int unsigned NUM_OPS = 5;
  localparam int unsigned CNT_BITS = 3;

  typedef struct packed {
    logic w4;
    logic w2;
    logic w1;
  } col_count_t;

endpackage

// File: rtl/add5_rst_sync.sv
module add5_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_ok_n = chain_q[STAGES-1];

endmodule

// File: rtl/add5_count_cell.sv
module add5_count_cell
  import add5_pkg::*;
(
  input  logic       in0,
  input  logic       in1,
  input  logic       in2,
  input  logic       in3,
  input  logic       in4,
  output col_count_t cnt
);

  logic lo_a, hi_a;
  logic lo_b, hi_b;

  always_comb begin
    // first three bits: a full adder
    lo_a = in0 ^ in1 ^ in2;
    hi_a = (in0 & in1) | (in0 & in2) | (in1 & in2);
    // the partial one-weight bit plus the last two bits
    lo_b = lo_a ^ in3 ^ in4;
    hi_b = (lo_a & in3) | (lo_a & in4) | (in3 & in4);
    // two weight-two bits, at most 2 in total
    cnt.w1 = lo_b;
    cnt.w2 = hi_a ^ hi_b;
    cnt.w4 = hi_a & hi_b;
  end

endmodule

// File: rtl/add5_col_array.sv
module add5_col_array
  import add5_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_e,
  output logic [W-1:0] vec_w1,
  output logic [W-1:0] vec_w2,
  output logic [W-1:0] vec_w4
);

  col_count_t  col_cnt [W];
  logic [W-1:0] raw_w1;
  logic [W-1:0] raw_w2;
  logic [W-1:0] raw_w4;

  for (genvar j = 0; j < W; j++) begin : g_col
    add5_count_cell u_cell (
      .in0 (op_a[j]),
      .in1 (op_b[j]),
      .in2 (op_c[j]),
      .in3 (op_d[j]),
      .in4 (op_e[j]),
      .cnt (col_cnt[j])
    );
    assign raw_w1[j] = col_cnt[j].w1;
    assign raw_w2[j] = col_cnt[j].w2;
    assign raw_w4[j] = col_cnt[j].w4;
  end

  // align by weight; bits pushed past the top column are dropped
  assign vec_w1 = raw_w1;
  assign vec_w2 = {raw_w2[W-2:0], 1'b0};
  assign vec_w4 = {raw_w4[W-3:0], 2'b00};

  logic unused_top_cnt;
  assign unused_top_cnt = ^{raw_w2[W-1], raw_w4[W-1:W-2]};

endmodule

// File: rtl/add5_csa_row.sv
module add5_csa_row #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  output logic [W-1:0] sum_vec,
  output logic [W-1:0] carry_vec
);

  logic [W-1:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_vec[i] = in_x[i] ^ in_y[i] ^ in_z[i];
    assign maj[i]     = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
  end

  assign carry_vec = {maj[W-2:0], 1'b0};

  logic unused_top_maj;
  assign unused_top_maj = maj[W-1];

endmodule

// File: rtl/add5_ripple_add.sv
module add5_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_p,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] total
);

  logic [W:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign total[i]   = in_p[i] ^ in_q[i] ^ chain[i];
    assign chain[i+1] = (in_p[i] & in_q[i]) | (chain[i] & (in_p[i] ^ in_q[i]));
  end

  logic unused_carry_out;
  assign unused_carry_out = chain[W];

endmodule

// File: rtl/five_op_adder.sv
module five_op_adder #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_e,
  output logic         out_valid,
  output logic [W-1:0] sum_out
);

  logic         rst_ok_n;
  logic [W-1:0] cnt_w1, cnt_w2, cnt_w4;
  logic [W-1:0] csa_s, csa_c;
  logic [W-1:0] add_total;
  logic         res_en;
  logic [W-1:0] res_d, res_q;
  logic         vld_d, vld_q;

  add5_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  add5_col_array #(.W(W)) u_cols (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_c   (op_c),
    .op_d   (op_d),
    .op_e   (op_e),
    .vec_w1 (cnt_w1),
    .vec_w2 (cnt_w2),
    .vec_w4 (cnt_w4)
  );

  add5_csa_row #(.W(W)) u_csa (
    .in_x      (cnt_w1),
    .in_y      (cnt_w2),
    .in_z      (cnt_w4),
    .sum_vec   (csa_s),
    .carry_vec (csa_c)
  );

  add5_ripple_add #(.W(W)) u_cpa (
    .in_p  (csa_s),
    .in_q  (csa_c),
    .total (add_total)
  );

  always_comb begin
    res_en = in_valid;
    res_d  = res_en ? add_total : res_q;
    vld_d  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign sum_out   = res_q;
  assign out_valid = vld_q;

endmodule

// File: rtl/add5_checker.sv
module add5_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_ok_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic [W-1:0] op_d,
  input logic [W-1:0] op_e,
  input logic [W-1:0] cnt_w1,
  input logic [W-1:0] cnt_w2,
  input logic [W-1:0] cnt_w4,
  input logic [W-1:0] csa_s,
  input logic [W-1:0] csa_c,
  input logic         out_valid,
  input logic [W-1:0] sum_out
);

  logic [W+2:0] wide_ref;
  logic [W-1:0] mod_ref;
  logic [W-1:0] cnt_total;
  logic [W-1:0] csa_total;

  assign wide_ref  = {3'b000, op_a} + {3'b000, op_b} + {3'b000, op_c}
                   + {3'b000, op_d} + {3'b000, op_e};
  assign mod_ref   = wide_ref[W-1:0];
  assign cnt_total = cnt_w1 + cnt_w2 + cnt_w4;
  assign csa_total = csa_s + csa_c;

  a_r1_count_weights: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cnt_total == mod_ref);

  a_r2_csa_keeps_value: assert property (@(posedge clk) disable iff (!rst_ok_n)
    csa_total == cnt_total);

  a_r3_result: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_valid |=> sum_out == $past(mod_ref));

  a_r5_valid_high: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_valid |=> out_valid);

  a_r5_valid_low: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> !out_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> $stable(sum_out));

  a_r7_reset_state: assert property (@(posedge clk)
    !rst_ok_n |-> (!out_valid && sum_out == '0));

endmodule

bind five_op_adder add5_checker #(.W(W)) u_add5_chk (
  .clk       (clk),
  .rst_ok_n  (rst_ok_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_c      (op_c),
  .op_d      (op_d),
  .op_e      (op_e),
  .cnt_w1    (cnt_w1),
  .cnt_w2    (cnt_w2),
  .cnt_w4    (cnt_w4),
  .csa_s     (csa_s),
  .csa_c     (csa_c),
  .out_valid (out_valid),
  .sum_out   (sum_out)
);

// File: tb/five_op_adder_bench.sv
module five_op_adder_bench;

  localparam int unsigned W = 8;
  localparam time CLK_P = 8ns;
  localparam logic [W-1:0] ONES = '1;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] op_a, op_b, op_c, op_d, op_e;
  logic         out_valid;
  logic [W-1:0] sum_out;

  int total;
  int bad;

  five_op_adder #(.W(W)) u_five_op_adder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .op_d      (op_d),
    .op_e      (op_e),
    .out_valid (out_valid),
    .sum_out   (sum_out)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  function automatic logic [W-1:0] mod_sum(input logic [W-1:0] a, b, c, d, e);
    int unsigned s;
    s = int'(a) + int'(b) + int'(c) + int'(d) + int'(e);
    return W'(s % (1 << W));
  endfunction

  task automatic check(input string req, input logic exp_v, input logic [W-1:0] exp_s);
    total++;
    if (out_valid !== exp_v || sum_out !== exp_s) begin
      bad++;
      $display("FAIL %s: got valid=%b sum=%0d, expected valid=%b sum=%0d",
               req, out_valid, sum_out, exp_v, exp_s);
    end
  endtask

  task automatic drive(input logic v, input logic [W-1:0] a, b, c, d, e);
    in_valid = v;
    op_a = a; op_b = b; op_c = c; op_d = d; op_e = e;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: got no end of test, expected end before timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    {op_a, op_b, op_c, op_d, op_e} = '0;
    repeat (3) @(negedge clk);
    // R7: reset state, even with valid operands applied
    drive(1'b1, 8'd9, 8'd9, 8'd9, 8'd9, 8'd9);
    check("R7 reset", 1'b0, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 after release idle", 1'b0, '0);

    // R1: every pattern of five bits in column 0
    for (int p = 0; p < 32; p++) begin
      drive(1'b1, W'(p & 1), W'((p >> 1) & 1), W'((p >> 2) & 1),
            W'((p >> 3) & 1), W'((p >> 4) & 1));
      check("R1 counter cell", 1'b1, W'($countones(p[4:0])));
    end

    // R2/R4: five ones in each single column
    for (int j = 0; j < W; j++) begin
      logic [W-1:0] m;
      m = W'(1) << j;
      drive(1'b1, m, m, m, m, m);
      check("R2 column alignment", 1'b1, W'((5 << j) % (1 << W)));
    end

    // R4: all ones overflow
    drive(1'b1, ONES, ONES, ONES, ONES, ONES);
    check("R4 overflow discard", 1'b1, 8'd251);

    // R6: idle cycles with changing operands keep the result
    drive(1'b1, 8'd10, 8'd20, 8'd30, 8'd40, 8'd50);
    check("R3 known sum", 1'b1, 8'd150);
    held = 8'd150;
    drive(1'b0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5);
    check("R6 hold idle", 1'b0, held);
    drive(1'b0, ONES, 8'd77, 8'd3, 8'd200, 8'd5);
    check("R6 hold idle second", 1'b0, held);

    // R3/R5/R8: back-to-back random sets
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a, b, c, d, e;
      a = W'($urandom); b = W'($urandom); c = W'($urandom);
      d = W'($urandom); e = W'($urandom);
      drive(1'b1, a, b, c, d, e);
      check("R8 back-to-back R3 sum", 1'b1, mod_sum(a, b, c, d, e));
    end

    // R5: valid drops one clock after in_valid drops
    drive(1'b0, '0, '0, '0, '0, '0);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R5 valid drop: got %b, expected 0", out_valid);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule